// File: doc/BRIEF.md
# Decimal-capable byte ALU

This block is the arithmetic and logic stage of a small byte-oriented processor. It takes a source byte, a destination byte, an incoming carry and a five-bit operation code, and it produces a result byte, a second byte for the wide operations, and carry, negative and zero flags. All of this happens in the same cycle. The three flags can also be captured in a small status register when the caller asserts a write-enable. The caller can route the registered carry back into the carry input, which makes multi-byte arithmetic possible, one byte per cycle.

The operation set covers binary addition and subtraction, with and without carry. It also has packed-decimal addition and subtraction that fold in the carry, compare, the bitwise operations, increment and decrement, a nibble exchange, four rotates, an unsigned multiply and a 16-bit pair decrement. Carry after any subtraction means "no borrow". All datapath pins are plain levels with no handshake, because the block has no internal storage on the data path. The only state is the status register.

Top module: `bcd_alu`

## Requirements
- R1: ADD (code 0) gives dst+src and ADC (code 1) gives dst+src+cin. The result is the low 8 bits and c_o is the carry out of bit 7.
- R2: SUB (code 2) gives dst−src and SBB (code 3) gives dst−src−1+cin. The result is taken modulo 256, and c_o is 1 exactly when no borrow occurred (true difference ≥ 0).
- R3: CMP (code 4) sets c_o, n_o and z_o as SUB would for dst−src. res_o equals dst_i unchanged.
- R4: DAC (code 5) treats both operands as two-digit packed BCD (high nibble is tens) and returns the BCD form of (dst+src+cin) mod 100. c_o is 1 when that sum reaches 100.
- R5: DSB (code 6) on packed BCD operands returns the BCD form of (dst−src−1+cin) mod 100. c_o is 1 when the decimal difference is ≥ 0.
- R6: AND (7), OR (8), XOR (9), INV of dst (10), MOV of src (11) and TST of dst (12) always return c_o = 0, whatever cin is.
- R7: INC (13) gives dst+1 with c_o the carry out. DEC (14) gives dst−1 with c_o = 0 only when dst was 0x00.
- R8: RL (16) and RR (18) rotate dst by one place, left or right. The bit that leaves also enters the vacated end and goes to c_o. RLC (17) and RRC (19) rotate through carry: cin fills the vacated end and the leaving bit goes to c_o.
- R9: SWAP (15) exchanges the two nibbles of dst, and c_o is bit 0 of the swapped result.
- R10: MPY (20) forms the unsigned 16-bit product src×dst, with the high byte on res_hi_o and the low byte on res_o. c_o is 0, and n_o and z_o come from the high byte. For every operation except MPY and DECD, res_hi_o is 0.
- R11: DECD (21) decrements the 16-bit pair {src_i (high), dst_i (low)}, returning the high byte on res_hi_o and the low byte on res_o. c_o is 0 only on the 0x0000 to 0xFFFF wrap. n_o is bit 15 and z_o is set when all 16 bits are zero.
- R12: Apart from CMP, MPY and DECD, n_o is bit 7 of res_o and z_o is 1 exactly when res_o is zero.
- R13: The status outputs st_c_o, st_n_o and st_z_o are 0 after reset. On a clock edge with flag_we_i high they take the values that c_o, n_o and z_o had before that edge. With flag_we_i low they hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| src_i | input | 8 | Source operand (high byte of the pair for DECD) |
| dst_i | input | 8 | Destination operand (low byte of the pair for DECD) |
| cin_i | input | 1 | Incoming carry |
| flag_we_i | input | 1 | Capture flags into the status register |
| res_o | output | 8 | Result byte (low byte for MPY and DECD) |
| res_hi_o | output | 8 | High byte for MPY and DECD, otherwise 0 |
| c_o | output | 1 | Carry flag of the current operation |
| n_o | output | 1 | Negative flag of the current operation |
| z_o | output | 1 | Zero flag of the current operation |
| st_c_o | output | 1 | Registered carry |
| st_n_o | output | 1 | Registered negative |
| st_z_o | output | 1 | Registered zero |

## Verification
The status register can capture one operation's flags on the same edge at which the next operation reads the carry that is being replaced. This happens when cin_i is fed from st_c_o while flag_we_i stays high for consecutive cycles. The bench sets this up by splitting 16-bit additions and subtractions into a low-byte ADD or SUB followed by a high-byte ADC or SBB, with the carry looped back. It judges the outcome against the full 16-bit sum or difference and its final carry or borrow. A following phase keeps flag_we_i low while operations with different flags run, and it checks that the register does not move.

// File: rtl/bcd_alu_pkg.sv
`timescale 1ns/10ps
package bcd_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBB  = 5'd3,
    OP_CMP  = 5'd4,
    OP_DAC  = 5'd5,
    OP_DSB  = 5'd6,
    OP_AND  = 5'd7,
    OP_OR   = 5'd8,
    OP_XOR  = 5'd9,
    OP_INV  = 5'd10,
    OP_MOV  = 5'd11,
    OP_TST  = 5'd12,
    OP_INC  = 5'd13,
    OP_DEC  = 5'd14,
    OP_SWAP = 5'd15,
    OP_RL   = 5'd16,
    OP_RLC  = 5'd17,
    OP_RR   = 5'd18,
    OP_RRC  = 5'd19,
    OP_MPY  = 5'd20,
    OP_DECD = 5'd21
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic n;
    logic z;
  } alu_flags_t;

endpackage

// File: rtl/bcd_alu_dec.sv
`timescale 1ns/10ps
// Packed-decimal adder/subtractor. The ripple term is a carry when adding
// and a borrow when subtracting.
module bcd_alu_dec #(
  parameter int DIGITS = 2
) (
  input  logic [4*DIGITS-1:0] a_i,
  input  logic [4*DIGITS-1:0] b_i,
  input  logic                cin_i,
  input  logic                sub_i,
  output logic [4*DIGITS-1:0] res_o,
  output logic                cout_o
);
  localparam int NW = 4;

  logic ripple [DIGITS+1];

  assign ripple[0] = sub_i ? ~cin_i : cin_i;
  assign cout_o    = sub_i ? ~ripple[DIGITS] : ripple[DIGITS];

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [NW:0]   add_t;
    logic [NW:0]   sub_t;
    logic [NW-1:0] dig_a;
    logic [NW-1:0] dig_b;
    logic [NW-1:0] dig_r;
    logic          dig_k;

    assign dig_a = a_i[g*NW +: NW];
    assign dig_b = b_i[g*NW +: NW];

    always_comb begin
      add_t = {1'b0, dig_a} + {1'b0, dig_b} + {{NW{1'b0}}, ripple[g]};
      sub_t = {1'b0, dig_a} - {1'b0, dig_b} - {{NW{1'b0}}, ripple[g]};
      if (sub_i) begin
        if (sub_t[NW]) begin
          dig_r = sub_t[NW-1:0] + 4'd10;
          dig_k = 1'b1;
        end else begin
          dig_r = sub_t[NW-1:0];
          dig_k = 1'b0;
        end
      end else if (add_t > 5'd9) begin
        dig_r = add_t[NW-1:0] + 4'd6;
        dig_k = 1'b1;
      end else begin
        dig_r = add_t[NW-1:0];
        dig_k = 1'b0;
      end
    end

    assign ripple[g+1]         = dig_k;
    assign res_o[g*NW +: NW]   = dig_r;
  end
endmodule

// File: rtl/bcd_alu_rot.sv
`timescale 1ns/10ps
// Single-place rotates and the nibble exchange.
module bcd_alu_rot
  import bcd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] d_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int H = W / 2;

  always_comb begin
    res_o  = d_i;
    cout_o = 1'b0;
    case (op_i)
      OP_RL: begin
        res_o  = {d_i[W-2:0], d_i[W-1]};
        cout_o = d_i[W-1];
      end
      OP_RLC: begin
        res_o  = {d_i[W-2:0], cin_i};
        cout_o = d_i[W-1];
      end
      OP_RR: begin
        res_o  = {d_i[0], d_i[W-1:1]};
        cout_o = d_i[0];
      end
      OP_RRC: begin
        res_o  = {cin_i, d_i[W-1:1]};
        cout_o = d_i[0];
      end
      OP_SWAP: begin
        res_o  = {d_i[H-1:0], d_i[W-1:H]};
        cout_o = d_i[H];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_alu_flags.sv
`timescale 1ns/10ps
// Status register for carry, negative and zero.
module bcd_alu_flags
  import bcd_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_i,
  input  alu_flags_t d_i,
  output alu_flags_t q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (we_i) q_o <= d_i;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o)); // R13
  AST_FLAG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == $past(d_i))); // R13
endmodule

// File: rtl/bcd_alu.sv
`timescale 1ns/10ps
module bcd_alu
  import bcd_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [4:0]   op_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] dst_i,
  input  logic         cin_i,
  input  logic         flag_we_i,
  output logic [W-1:0] res_o,
  output logic [W-1:0] res_hi_o,
  output logic         c_o,
  output logic         n_o,
  output logic         z_o,
  output logic         st_c_o,
  output logic         st_n_o,
  output logic         st_z_o
);
  localparam int DIGITS = W / 4;
  localparam int W2     = 2 * W;

  alu_op_e      op;
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   sum;
  logic [W-1:0] dec_res;
  logic         dec_c;
  logic [W-1:0] rot_res;
  logic         rot_c;
  logic [W2-1:0] prod;
  logic [W2-1:0] pair;
  logic [W2-1:0] pair_m1;
  alu_flags_t   flags_nx;
  alu_flags_t   flags_q;

  assign op = alu_op_e'(op_i);

  // Shared binary adder: subtraction adds the inverted source.
  always_comb begin
    b_eff = src_i;
    c_eff = 1'b0;
    case (op)
      OP_ADC:         c_eff = cin_i;
      OP_SUB, OP_CMP: begin b_eff = ~src_i; c_eff = 1'b1;  end
      OP_SBB:         begin b_eff = ~src_i; c_eff = cin_i; end
      OP_INC:         begin b_eff = '0;     c_eff = 1'b1;  end
      OP_DEC:         b_eff = '1;
      default: ;
    endcase
    sum = {1'b0, dst_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
  end

  bcd_alu_dec #(.DIGITS(DIGITS)) u_dec (
    .a_i(dst_i), .b_i(src_i), .cin_i(cin_i), .sub_i(op == OP_DSB),
    .res_o(dec_res), .cout_o(dec_c)
  );

  bcd_alu_rot #(.W(W)) u_rot (
    .op_i(op), .d_i(dst_i), .cin_i(cin_i), .res_o(rot_res), .cout_o(rot_c)
  );

  assign prod    = {{W{1'b0}}, src_i} * {{W{1'b0}}, dst_i};
  assign pair    = {src_i, dst_i};
  assign pair_m1 = pair - {{(W2-1){1'b0}}, 1'b1};

  always_comb begin
    res_o    = dst_i;
    res_hi_o = '0;
    c_o      = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC: begin
        res_o = sum[W-1:0];
        c_o   = sum[W];
      end
      OP_CMP:  c_o = sum[W];
      OP_DAC, OP_DSB: begin
        res_o = dec_res;
        c_o   = dec_c;
      end
      OP_AND:  res_o = src_i & dst_i;
      OP_OR:   res_o = src_i | dst_i;
      OP_XOR:  res_o = src_i ^ dst_i;
      OP_INV:  res_o = ~dst_i;
      OP_MOV:  res_o = src_i;
      OP_SWAP, OP_RL, OP_RLC, OP_RR, OP_RRC: begin
        res_o = rot_res;
        c_o   = rot_c;
      end
      OP_MPY: begin
        res_o    = prod[W-1:0];
        res_hi_o = prod[W2-1:W];
      end
      OP_DECD: begin
        res_o    = pair_m1[W-1:0];
        res_hi_o = pair_m1[W2-1:W];
        c_o      = |pair;
      end
      default: ;
    endcase
  end

  always_comb begin
    n_o = res_o[W-1];
    z_o = (res_o == '0);
    case (op)
      OP_CMP: begin
        n_o = sum[W-1];
        z_o = (sum[W-1:0] == '0);
      end
      OP_MPY: begin
        n_o = res_hi_o[W-1];
        z_o = (res_hi_o == '0);
      end
      OP_DECD: begin
        n_o = pair_m1[W2-1];
        z_o = (pair_m1 == '0);
      end
      default: ;
    endcase
  end

  assign flags_nx = '{c: c_o, n: n_o, z: z_o};

  bcd_alu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .we_i(flag_we_i), .d_i(flags_nx), .q_o(flags_q)
  );

  assign st_c_o = flags_q.c;
  assign st_n_o = flags_q.n;
  assign st_z_o = flags_q.z;

  function automatic logic all_digits_ok(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) begin
      if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    end
    return ok;
  endfunction

  AST_CMP_KEEPS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_CMP) |-> (res_o == dst_i)); // R3
  AST_DAC_DIGITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DAC && all_digits_ok(src_i) && all_digits_ok(dst_i)) |-> all_digits_ok(res_o)); // R4
  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i >= OP_AND && op_i <= OP_TST) |-> !c_o); // R6
  AST_MPY_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_MPY && src_i == '0) |-> (res_o == '0 && res_hi_o == '0 && z_o)); // R10
  AST_DECD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_DECD && src_i == '0 && dst_i == '0) |-> (!c_o && res_o == '1 && res_hi_o == '1)); // R11
endmodule

// File: tb/sim_bcd_alu.sv
`timescale 1ns/10ps
module sim_bcd_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] op = 5'd0;
  logic [7:0] src = 8'd0;
  logic [7:0] dst = 8'd0;
  logic       cin_r = 1'b0;
  logic       use_st = 1'b0;
  logic       flag_we = 1'b0;
  logic       cin_drv;
  logic [7:0] res, res_hi;
  logic       c, n, z, st_c, st_n, st_z;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  assign cin_drv = use_st ? st_c : cin_r;

  bcd_alu u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op), .src_i(src), .dst_i(dst),
    .cin_i(cin_drv), .flag_we_i(flag_we), .res_o(res), .res_hi_o(res_hi),
    .c_o(c), .n_o(n), .z_o(z), .st_c_o(st_c), .st_n_o(st_n), .st_z_o(st_z)
  );

  function automatic bit is_bcd(int v);
    return ((v % 16) < 10) && ((v / 16) < 10);
  endfunction
  function automatic int from_bcd(int v);
    return (v / 16) * 10 + (v % 16);
  endfunction
  function automatic int to_bcd(int v);
    return (v / 10) * 16 + (v % 10);
  endfunction

  // Reference model: {hi, res, c, n, z}
  function automatic logic [18:0] ref_calc(int o, int s, int d, bit ci);
    int t; int r; int h; bit cy; bit nf; bit zf; bit own_nz;
    t = 0; r = d; h = 0; cy = 0; own_nz = 0; nf = 0; zf = 0;
    case (o)
      0:  begin t = d + s;          cy = (t > 255); r = t % 256; end
      1:  begin t = d + s + ci;     cy = (t > 255); r = t % 256; end
      2:  begin t = d - s;          cy = (t >= 0);  r = (t + 256) % 256; end
      3:  begin t = d - s - 1 + ci; cy = (t >= 0);  r = (t + 256) % 256; end
      4:  begin t = (d - s + 256) % 256; cy = (d >= s); r = d;
                own_nz = 1; nf = (t >= 128); zf = (t == 0); end
      5:  begin t = from_bcd(d) + from_bcd(s) + ci; cy = (t >= 100); r = to_bcd(t % 100); end
      6:  begin t = from_bcd(d) - from_bcd(s) - 1 + ci; cy = (t >= 0);
                r = to_bcd((t + 100) % 100); end
      7:  r = d & s;
      8:  r = d | s;
      9:  r = d ^ s;
      10: r = 255 - d;
      11: r = s;
      12: r = d;
      13: begin t = d + 1; cy = (t > 255); r = t % 256; end
      14: begin cy = (d != 0); r = (d + 255) % 256; end
      15: begin r = (d % 16) * 16 + d / 16; cy = r % 2; end
      16: begin r = (d * 2) % 256 + d / 128; cy = (d >= 128); end
      17: begin r = (d * 2) % 256 + ci;      cy = (d >= 128); end
      18: begin r = d / 2 + (d % 2) * 128;   cy = d % 2; end
      19: begin r = d / 2 + ci * 128;        cy = d % 2; end
      20: begin t = s * d; h = t / 256; r = t % 256;
                own_nz = 1; nf = (h >= 128); zf = (h == 0); end
      21: begin t = (s * 256 + d + 65535) % 65536; cy = ((s + d) != 0);
                h = t / 256; r = t % 256; own_nz = 1; nf = (t >= 32768); zf = (t == 0); end
      default: r = d;
    endcase
    if (!own_nz) begin nf = (r >= 128); zf = (r == 0); end
    return {8'(h), 8'(r), cy, nf, zf};
  endfunction

  task automatic sweep(input int o, input bit ci, input bit bcd, input string tag);
    int misses;
    logic [18:0] exp_v, got_v;
    misses = 0;
    flag_we = 1'b0;
    use_st  = 1'b0;
    for (int s = 0; s < 256; s++) begin
      for (int d = 0; d < 256; d++) begin
        if (bcd && !(is_bcd(s) && is_bcd(d))) continue;
        op = 5'(o); src = 8'(s); dst = 8'(d); cin_r = ci;
        #0.05;
        exp_v = ref_calc(o, s, d, ci);
        got_v = {res_hi, res, c, n, z};
        if (got_v !== exp_v) begin
          if (misses == 0)
            $display("FAIL %s op=%0d src=%h dst=%h cin=%b actual=%h expected=%h",
                     tag, o, s, d, ci, got_v, exp_v);
          misses++;
        end
      end
    end
    total++;
    if (misses != 0) bad++;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic t_reset;
    check({st_c, st_n, st_z} === 3'b000, "R13 reset state", {st_c, st_n, st_z}, 0);
  endtask

  task automatic t_add;    sweep(0, 0, 0, "R1 ADD"); sweep(1, 0, 0, "R1 ADC c0"); sweep(1, 1, 0, "R1 ADC c1"); endtask
  task automatic t_sub;    sweep(2, 1, 0, "R2 SUB"); sweep(3, 0, 0, "R2 SBB c0"); sweep(3, 1, 0, "R2 SBB c1"); endtask
  task automatic t_cmp;    sweep(4, 0, 0, "R3 CMP"); endtask
  task automatic t_dac;    sweep(5, 0, 1, "R4 DAC c0"); sweep(5, 1, 1, "R4 DAC c1"); endtask
  task automatic t_dsb;    sweep(6, 0, 1, "R5 DSB c0"); sweep(6, 1, 1, "R5 DSB c1"); endtask
  task automatic t_logic;
    for (int o = 7; o <= 12; o++) sweep(o, 1, 0, "R6 logic");
  endtask
  task automatic t_incdec; sweep(13, 1, 0, "R7 INC"); sweep(14, 1, 0, "R7 DEC"); endtask
  task automatic t_rot;
    sweep(16, 1, 0, "R8 RL"); sweep(17, 0, 0, "R8 RLC c0"); sweep(17, 1, 0, "R8 RLC c1");
    sweep(18, 0, 0, "R8 RR"); sweep(19, 0, 0, "R8 RRC c0"); sweep(19, 1, 0, "R8 RRC c1");
  endtask
  task automatic t_swap;   sweep(15, 0, 0, "R9 SWAP"); endtask
  task automatic t_mpy;    sweep(20, 0, 0, "R10 MPY"); endtask
  task automatic t_decd;   sweep(21, 1, 0, "R11 DECD"); endtask

  task automatic t_nz_edges;
    op = 5'd0; src = 8'h80; dst = 8'h80; cin_r = 0; #0.05;
    check({res, c, n, z} === {8'h00, 3'b101}, "R12 ADD wrap to zero", {res, c, n, z}, {8'h00, 3'b101});
    op = 5'd2; src = 8'h01; dst = 8'h00; #0.05;
    check({res, c, n, z} === {8'hFF, 3'b010}, "R12 SUB negative", {res, c, n, z}, {8'hFF, 3'b010});
  endtask

  // Multi-byte arithmetic with the registered carry looped back (R13).
  task automatic chain(input int lo_op, input int hi_op, input int a, input int b,
                       input int exp16, input bit exp_c);
    logic [7:0] lo_r, hi_r;
    @(negedge clk);
    op = 5'(lo_op); dst = 8'(a % 256); src = 8'(b % 256);
    use_st = 1'b0; cin_r = 1'b0; flag_we = 1'b1;
    #1 lo_r = res;
    @(negedge clk);
    op = 5'(hi_op); dst = 8'(a / 256); src = 8'(b / 256); use_st = 1'b1;
    #1 hi_r = res;
    @(posedge clk); #1;
    flag_we = 1'b0; use_st = 1'b0;
    check({hi_r, lo_r} === 16'(exp16), "R13 chained value", {hi_r, lo_r}, exp16);
    check(st_c === exp_c, "R13 chained carry", st_c, exp_c);
  endtask

  task automatic t_chain;
    chain(0, 1, 16'h12FF, 16'h3401, 16'h4700, 1'b0);
    chain(0, 1, 16'hF0FF, 16'h1001, 16'h0100, 1'b1);
    chain(2, 3, 16'h1200, 16'h0001, 16'h11FF, 1'b1);
    chain(2, 3, 16'h0000, 16'h0001, 16'hFFFF, 1'b0);
  endtask

  task automatic t_hold;
    logic [2:0] held;
    @(negedge clk);
    op = 5'd2; src = 8'h01; dst = 8'h00; flag_we = 1'b1; use_st = 1'b0;
    @(posedge clk); #1;
    held = {st_c, st_n, st_z};
    check(held === 3'b010, "R13 load", held, 3'b010);
    @(negedge clk);
    flag_we = 1'b0; op = 5'd7; src = 8'h00; dst = 8'hFF;
    #1 check({c, n, z} === 3'b001, "R13 new flags visible", {c, n, z}, 3'b001);
    repeat (3) @(posedge clk);
    #1 check({st_c, st_n, st_z} === held, "R13 hold with we low", {st_c, st_n, st_z}, held);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk) rst_n = 1'b1;
    #1 t_reset();
    t_add();
    t_sub();
    t_cmp();
    t_dac();
    t_dsb();
    t_logic();
    t_incdec();
    t_rot();
    t_swap();
    t_mpy();
    t_decd();
    t_nz_edges();
    t_chain();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1900000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule